// File: doc/BRIEF.md
# Four-Channel Cycle-Steal DMA Engine

This block moves data between memory locations on behalf of up to four independent channels. It shares one memory bus with a processor: before each move it raises a bus request and waits for a grant. Once granted it performs one read cycle and one write cycle, then hands the bus straight back. Every request causes exactly one unit to move, either a byte or a 16-bit word, chosen per channel.

Each channel holds a source address, a destination address, a count reload value and a set of mode controls, all presented on configuration inputs. Exactly one of the two addresses may advance; the other stays where it was set. The working pointer and down-counter are loaded only when the first transfer after enable takes place. When the counter underflows the channel raises an interrupt pulse. It then either stops (single mode) or reloads pointer and counter and keeps serving requests (repeat mode).

Requests come from a falling edge or from either edge of a per-channel trigger input, or from a per-channel software trigger pulse. Pending requests are latched and served in fixed priority order.

Top module: `dma_cs`

## Requirements
- R1: When several enabled channels have pending requests at the same arbitration point, the lowest-numbered channel is served first; channel 0 wins over 1, 1 over 2, and 2 over 3.
- R2: Each served request performs exactly one unit move. With `cfg_word` set, the 16 bits read are written. With it clear, only a byte moves, carried on `mem_wdata[7:0]` and flagged by `mem_word`=0.
- R3: In the 2-bit direction field of a channel, bit 0 makes the source advance and bit 1 makes the destination advance. When both bits are set, only the source advances. A side that does not advance always uses its configured address.
- R4: An advancing address moves by 1 after a byte unit and by 2 after a word unit.
- R5: The first transfer after enable uses the configured address of the advancing side and takes the count from the reload value. A reload value N yields N+1 transfers before underflow.
- R6: In single mode, after the underflowing transfer the channel ignores all requests until its enable has been cleared and set again.
- R7: In repeat mode, the transfer after an underflow starts again from the configured address and reload count, and the channel keeps serving requests.
- R8: `irq[i]` is a one-cycle pulse in the cycle after the write of channel i's underflowing transfer, and at most one `irq` bit is high at a time.
- R9: While a channel's enable is low, its requests are dropped. Its pointer, counter and stopped state are discarded, so the next enable behaves as a fresh start.
- R10: With `cfg_both` clear, only a falling edge of `trig_in[i]` requests a transfer. With it set, both edges do. A high `sw_trig[i]` in any cycle also requests one.
- R11: A transfer raises `bus_req`, waits for `bus_gnt`, then spends one cycle with `mem_rd` followed by one cycle with `mem_wr`. `bus_req` drops in the cycle after the write. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | NCH | Per-channel enable |
| cfg_word | input | NCH | Unit size per channel: 1 = 16-bit, 0 = byte |
| cfg_repeat | input | NCH | 1 = repeat mode, 0 = single mode |
| cfg_both | input | NCH | 1 = both trigger edges request, 0 = falling edge only |
| cfg_dir | input | 2*NCH | Direction field per channel (bit 0 source forward, bit 1 destination forward) |
| cfg_src | input | AW*NCH | Source address per channel |
| cfg_dst | input | AW*NCH | Destination address per channel |
| cfg_reload | input | CW*NCH | Count reload value per channel |
| trig_in | input | NCH | Edge-sensitive request inputs |
| sw_trig | input | NCH | Software request pulses |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while bus_req is high |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_word | output | 1 | Size of the current access: 1 = 16-bit |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, registered by memory from the read cycle |
| irq | output | NCH | Per-channel underflow pulse |

## Verification
The checks assume that the bus grant, once given, stays high until the engine drops its request. They also assume read data is presented in the cycle after the read strobe, with no wait states. The bench's arbiter model waits a random zero to two cycles before granting and then holds the grant, and its memory model always answers in one cycle. Configuration is changed only while a channel is disabled and idle, and triggers are spaced so that each transfer finishes before the next stimulus.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } dma_st_e;

    localparam int DIR_SRC_BIT = 0;
    localparam int DIR_DST_BIT = 1;
    localparam int DIR_W       = 2;
endpackage

// File: rtl/dma_cs_edge.sv
module dma_cs_edge #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin,
    input  logic [NCH-1:0] sw,
    input  logic [NCH-1:0] both,
    output logic [NCH-1:0] hit
);
    logic [NCH-1:0] prev_q, prev_d;

    always_comb prev_d = pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_edge
        assign hit[g] = sw[g] | (both[g] ? (prev_q[g] ^ pin[g])
                                         : (prev_q[g] & ~pin[g]));
    end
endmodule

// File: rtl/dma_cs_prio.sv
module dma_cs_prio #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [IW-1:0]  idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_cs.sv
module dma_cs
    import dma_cs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 20,
    parameter int CW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       cfg_en,
    input  logic [NCH-1:0]       cfg_word,
    input  logic [NCH-1:0]       cfg_repeat,
    input  logic [NCH-1:0]       cfg_both,
    input  logic [DIR_W*NCH-1:0] cfg_dir,
    input  logic [AW*NCH-1:0]    cfg_src,
    input  logic [AW*NCH-1:0]    cfg_dst,
    input  logic [CW*NCH-1:0]    cfg_reload,
    input  logic [NCH-1:0]       trig_in,
    input  logic [NCH-1:0]       sw_trig,
    output logic                 bus_req,
    input  logic                 bus_gnt,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 mem_word,
    output logic [15:0]          mem_wdata,
    input  logic [15:0]          mem_rdata,
    output logic [NCH-1:0]       irq
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        dma_st_e                 st;
        logic [IW-1:0]           cur;
        logic [NCH-1:0]          pend;
        logic [NCH-1:0]          loaded;
        logic [NCH-1:0]          done;
        logic [NCH-1:0]          irq;
        logic [NCH-1:0][AW-1:0]  ptr;
        logic [NCH-1:0][CW-1:0]  cnt;
    } state_t;

    state_t q, d;

    logic [NCH-1:0] hit;
    logic           arb_any;
    logic [IW-1:0]  arb_idx;

    dma_cs_edge #(.NCH(NCH)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (trig_in),
        .sw    (sw_trig),
        .both  (cfg_both),
        .hit   (hit)
    );

    dma_cs_prio #(.NCH(NCH), .IW(IW)) i_prio (
        .req (q.pend & cfg_en & ~q.done),
        .any (arb_any),
        .idx (arb_idx)
    );

    // Working view of the channel being served
    int            chi;
    logic          src_fwd, dst_fwd;
    logic [AW-1:0] c_src, c_dst, base_ptr;
    logic [CW-1:0] base_cnt;

    always_comb begin
        chi      = int'(q.cur);
        c_src    = cfg_src[chi*AW +: AW];
        c_dst    = cfg_dst[chi*AW +: AW];
        src_fwd  = cfg_dir[chi*DIR_W + DIR_SRC_BIT];
        dst_fwd  = cfg_dir[chi*DIR_W + DIR_DST_BIT] & ~src_fwd;
        base_ptr = q.loaded[chi] ? q.ptr[chi]
                                 : (src_fwd ? c_src : c_dst);
        base_cnt = q.loaded[chi] ? q.cnt[chi] : cfg_reload[chi*CW +: CW];
    end

    always_comb begin
        d     = q;
        d.irq = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    d.cur = arb_idx;
                    d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) d.st = ST_RD;
            end
            ST_RD: d.st = ST_WR;
            ST_WR: begin
                d.st        = ST_IDLE;
                d.pend[chi] = 1'b0;
                d.ptr[chi]  = base_ptr + (cfg_word[chi] ? AW'(2) : AW'(1));
                if (base_cnt == '0) begin
                    d.irq[chi] = 1'b1;
                    if (cfg_repeat[chi]) begin
                        d.loaded[chi] = 1'b0;
                    end else begin
                        d.loaded[chi] = 1'b1;
                        d.done[chi]   = 1'b1;
                    end
                end else begin
                    d.cnt[chi]    = base_cnt - CW'(1);
                    d.loaded[chi] = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        d.pend   = (d.pend | (hit & ~d.done)) & cfg_en;
        d.loaded = d.loaded & cfg_en;
        d.done   = d.done & cfg_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_req   = (q.st != ST_IDLE);
        mem_rd    = (q.st == ST_RD);
        mem_wr    = (q.st == ST_WR);
        mem_word  = cfg_word[chi];
        mem_addr  = (q.st == ST_WR) ? (dst_fwd ? base_ptr : c_dst)
                                    : (src_fwd ? base_ptr : c_src);
        mem_wdata = mem_rdata;
        irq       = q.irq;
    end
endmodule

// File: rtl/dma_cs_chk.sv
module dma_cs_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic [NCH-1:0] irq
);
    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R11
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);
    // R11
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !bus_req);
    // R11
    granted_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (bus_req && $past(bus_gnt)));
    // R8
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));
    // R8
    irq_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> $past(mem_wr));
endmodule

bind dma_cs dma_cs_chk #(.NCH(NCH)) i_dma_cs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .irq     (irq)
);

// File: tb/test_dma_cs.sv
`timescale 1ns/1ps
module test_dma_cs;
    localparam int NCH = 4;
    localparam int AW  = 20;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NCH-1:0]    cfg_en, cfg_word, cfg_repeat, cfg_both, trig_in, sw_trig;
    logic [2*NCH-1:0]  cfg_dir;
    logic [AW*NCH-1:0] cfg_src, cfg_dst;
    logic [CW*NCH-1:0] cfg_reload;
    logic              bus_req, bus_gnt, mem_rd, mem_wr, mem_word;
    logic [AW-1:0]     mem_addr;
    logic [15:0]       mem_wdata, mem_rdata;
    logic [NCH-1:0]    irq;

    // bench-side configuration and model
    bit          c_en[NCH], c_word[NCH], c_rep[NCH], c_both[NCH], c_trig[NCH];
    logic [1:0]  c_dir[NCH];
    logic [19:0] c_src[NCH], c_dst[NCH];
    logic [15:0] c_rel[NCH];
    bit          m_loaded[NCH], m_done[NCH];
    logic [19:0] m_ptr[NCH];
    logic [15:0] m_cnt[NCH];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg_en[i]            = c_en[i];
            cfg_word[i]          = c_word[i];
            cfg_repeat[i]        = c_rep[i];
            cfg_both[i]          = c_both[i];
            trig_in[i]           = c_trig[i];
            cfg_dir[2*i +: 2]    = c_dir[i];
            cfg_src[AW*i +: AW]  = c_src[i];
            cfg_dst[AW*i +: AW]  = c_dst[i];
            cfg_reload[CW*i +: CW] = c_rel[i];
        end
    end

    dma_cs #(.NCH(NCH), .AW(AW), .CW(CW)) i_dma_cs (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
        .cfg_repeat(cfg_repeat), .cfg_both(cfg_both), .cfg_dir(cfg_dir),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_reload(cfg_reload),
        .trig_in(trig_in), .sw_trig(sw_trig), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_word(mem_word), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model: 4 KB, little-endian, one-cycle read latency
    logic [7:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= {mem[(mem_addr[11:0] + 12'd1)], mem[mem_addr[11:0]]};
        if (mem_wr) begin
            mem[mem_addr[11:0]] <= mem_wdata[7:0];
            if (mem_word) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
        end
    end

    // bus arbiter model: random delay, grant held while requested
    int gnt_wait = 0;
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_gnt  <= 1'b0;
            gnt_wait <= int'($urandom % 3);
        end else if (!bus_gnt) begin
            if (gnt_wait == 0) bus_gnt <= 1'b1;
            else gnt_wait <= gnt_wait - 1;
        end
    end

    // monitor
    int          n_chk = 0, n_err = 0, wr_cnt = 0;
    logic [19:0] last_addr, ord_addr[16];
    logic [15:0] last_data;
    bit          last_word;
    logic [NCH-1:0] irq_seen;
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            last_addr <= mem_addr;
            last_data <= mem_wdata;
            last_word <= mem_word;
            ord_addr[wr_cnt % 16] <= mem_addr;
            wr_cnt <= wr_cnt + 1;
        end
        if (rst_n) irq_seen <= irq_seen | irq;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_clear(input int ch);
        m_loaded[ch] = 1'b0;
        m_done[ch]   = 1'b0;
    endfunction

    function automatic void model_xfer(input int ch, output logic [19:0] s,
                                       output logic [19:0] d, output bit ie);
        bit sf, df;
        logic [19:0] bp;
        logic [15:0] bc;
        sf = c_dir[ch][0];
        df = c_dir[ch][1] & !sf;
        bp = m_loaded[ch] ? m_ptr[ch] : (sf ? c_src[ch] : c_dst[ch]);
        bc = m_loaded[ch] ? m_cnt[ch] : c_rel[ch];
        s  = sf ? bp : c_src[ch];
        d  = df ? bp : c_dst[ch];
        m_ptr[ch] = bp + (c_word[ch] ? 20'd2 : 20'd1);
        ie = (bc == 16'd0);
        if (ie) begin
            if (c_rep[ch]) m_loaded[ch] = 1'b0;
            else begin m_loaded[ch] = 1'b1; m_done[ch] = 1'b1; end
        end else begin
            m_cnt[ch]    = bc - 16'd1;
            m_loaded[ch] = 1'b1;
        end
    endfunction

    // kind 0: software pulse; kind 1: toggle trig_in
    task automatic xfer(input int ch, input int kind, input string tag);
        bit qual, elig, ie;
        logic [19:0] s, d;
        logic [15:0] ed;
        int n0;
        qual = (kind == 0) || c_both[ch] || c_trig[ch];
        elig = qual && c_en[ch] && !m_done[ch];
        ie = 1'b0;
        s = '0; d = '0; ed = '0;
        if (elig) begin
            model_xfer(ch, s, d, ie);
            ed = c_word[ch] ? {mem[s[11:0] + 12'd1], mem[s[11:0]]}
                            : {8'h00, mem[s[11:0]]};
        end
        @(negedge clk);
        n0 = wr_cnt;
        irq_seen = '0;
        if (kind == 0) begin
            sw_trig[ch] = 1'b1;
            @(negedge clk);
            sw_trig[ch] = 1'b0;
        end else begin
            c_trig[ch] = !c_trig[ch];
        end
        repeat (20) @(negedge clk);
        chk((wr_cnt - n0) == (elig ? 1 : 0), {tag, " R2 unit count"},
            32'(wr_cnt - n0), elig ? 32'd1 : 32'd0);
        if (elig) begin
            chk(last_addr == d, {tag, " R3 R4 dst address"}, 32'(last_addr), 32'(d));
            chk(last_word == c_word[ch], {tag, " R2 unit size"},
                32'(last_word), 32'(c_word[ch]));
            if (c_word[ch])
                chk(last_data == ed, {tag, " R2 word data"}, 32'(last_data), 32'(ed));
            else
                chk(last_data[7:0] == ed[7:0], {tag, " R2 byte data"},
                    32'(last_data[7:0]), 32'(ed[7:0]));
        end
        chk(irq_seen == (ie ? (4'b1 << ch) : 4'b0), {tag, " R8 irq"},
            32'(irq_seen), ie ? 32'(4'b1 << ch) : 32'd0);
        chk(!bus_req, {tag, " R11 bus released"}, 32'(bus_req), 32'd0);
    endtask

    task automatic setup(input int ch, input bit w, input bit rep, input bit both,
                         input logic [1:0] dir, input logic [19:0] s,
                         input logic [19:0] d, input logic [15:0] rel);
        @(negedge clk);
        c_en[ch] = 1'b0;
        model_clear(ch);
        @(negedge clk);
        c_word[ch] = w; c_rep[ch] = rep; c_both[ch] = both; c_dir[ch] = dir;
        c_src[ch] = s; c_dst[ch] = d; c_rel[ch] = rel;
        c_en[ch] = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < NCH; i++) begin
            c_en[i] = 0; c_word[i] = 0; c_rep[i] = 0; c_both[i] = 0; c_trig[i] = 0;
            c_dir[i] = 2'b00; c_src[i] = '0; c_dst[i] = '0; c_rel[i] = '0;
            model_clear(i);
        end
        sw_trig = '0;
        irq_seen = '0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !mem_rd && !mem_wr, "R11 reset bus idle",
            {bus_req, mem_rd, mem_wr}, 32'd0);
        chk(irq == '0, "R8 reset irq low", 32'(irq), 32'd0);

        // R5 R4 R6: single mode, word units, source forward, reload 2
        setup(0, 1, 0, 0, 2'b01, 20'h010, 20'h800, 16'd2);
        xfer(0, 0, "R5 first");
        xfer(0, 0, "R4 second");
        xfer(0, 0, "R6 underflow");
        xfer(0, 0, "R6 ignored after stop");
        // R9: requests dropped while disabled, then fresh start
        @(negedge clk); c_en[0] = 1'b0; model_clear(0);
        xfer(0, 0, "R9 disabled");
        @(negedge clk); c_en[0] = 1'b1;
        xfer(0, 0, "R9 restart");

        // R7 R10: byte, destination forward, repeat, falling edge only
        setup(1, 0, 1, 0, 2'b10, 20'h120, 20'h900, 16'd1);
        xfer(1, 1, "R10 rising ignored");
        xfer(1, 1, "R10 falling");
        xfer(1, 0, "R7 underflow");
        xfer(1, 0, "R7 restart");

        // R10 both edges
        setup(2, 1, 0, 1, 2'b01, 20'h200, 20'hA00, 16'd4);
        xfer(2, 1, "R10 both rising");
        xfer(2, 1, "R10 both falling");

        // R3 both-forward setting behaves as source forward
        setup(3, 0, 0, 0, 2'b11, 20'h300, 20'hB00, 16'd3);
        xfer(3, 0, "R3 both set");
        xfer(3, 0, "R3 both set second");

        // R1 priority
        begin
            logic [19:0] s, d[NCH];
            bit ie;
            int n0;
            for (int i = 0; i < NCH; i++)
                setup(i, 0, 0, 0, 2'b00, 20'h040 + 20'(i), 20'hC00 + 20'(16*i), 16'd5);
            for (int i = 0; i < NCH; i++) model_xfer(i, s, d[i], ie);
            @(negedge clk);
            n0 = wr_cnt;
            sw_trig = 4'b1111;
            @(negedge clk);
            sw_trig = '0;
            repeat (60) @(negedge clk);
            chk(wr_cnt - n0 == NCH, "R1 all served", 32'(wr_cnt - n0), NCH);
            for (int i = 0; i < NCH; i++)
                chk(ord_addr[(n0 + i) % 16] == d[i], "R1 order",
                    32'(ord_addr[(n0 + i) % 16]), 32'(d[i]));
        end

        // random traffic
        for (int it = 0; it < 80; it++) begin
            int ch;
            ch = int'($urandom % NCH);
            if (($urandom % 4) == 0)
                setup(ch, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                      20'($urandom % 1024), 20'(2048 + $urandom % 1024),
                      16'($urandom % 4));
            if (($urandom % 10) == 0) begin
                @(negedge clk); c_en[ch] = 1'b0; model_clear(ch);
                xfer(ch, 0, "R9 random disabled");
                @(negedge clk); c_en[ch] = 1'b1;
            end
            xfer(ch, int'($urandom % 2), "random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule